// File: doc/BRIEF.md
# Serial Key Gate for Clock Register Access

This block sits beside an SRAM on a simple bus and hides a set of clock registers behind a serial unlock key. The bus presents each access as a one-clock strobe: a read strobe for a cycle with chip enable and output enable active, and a write strobe for a cycle with chip enable and write enable active. Only data bit 0 takes part. While the gate is locked, every cycle goes to the SRAM as normal. The block compares the data bit of successive writes against a fixed 64-bit key. The addresses of these writes do not matter.

Once all 64 key bits have matched, the next 64 bus cycles are transfer cycles. A read strobe returns one bit of a 64-bit snapshot of the clock registers, which is taken at the moment of unlock. A write strobe shifts one bit toward the clock core. Each complete byte of written bits is handed to the core with its register index. During these 64 cycles the SRAM select is held low, so the memory is neither read nor written. After the last transfer cycle, the gate locks again. An external active-low reset pin can cut a transfer short, but only when the reset-enable bit in the snapshot is 0.

Top module: `serial_key_gate`

## Requirements
- R1: After reset, mem_sel is 1, dq0_oe is 0 and load_vld is 0.
- R2: The key is 64 bits long and is taken from dq0_in, one bit per write strobe. Key bit i is bit (i mod 8) of byte i/8 of the sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C, so the least significant bit of each byte goes first. mem_sel stays 1 through all 64 key writes, including the last one. mem_sel is 0 from the clock edge that ends the 64th matching write.
- R3: A key write whose bit differs from the key bit under the pointer freezes recognition. Every later write is then ignored, even a full correct key, until a read strobe occurs.
- R4: A read strobe while locked returns the comparison pointer to key bit 0. Recognition then restarts from the first key bit, and bits sent before the read do not count.
- R5: In transfer cycle k (k = 0..63), a read strobe drives dq0_oe to 1 and dq0_out to bit k of clk_regs as sampled on the clock edge that ended the unlocking write. Bit k is bit k mod 8 of register k/8. Later changes on clk_regs have no effect on the bits read out.
- R6: When transfer cycles 8g to 8g+7 are all write strobes, load_vld is 1 for one clock after the eighth of them. In that clock, load_idx equals g and load_byte holds the eight written bits, with the first bit written in bit 0.
- R7: A byte group that contains any read transfer cycle produces no load_vld pulse.
- R8: After 64 transfer cycles, mem_sel returns to 1. A key written after that without an intervening read strobe does not unlock the gate.
- R9: In the transfer phase, if bit 36 of the snapshot (the reset-enable bit) is 0, then rst_pin_n low on a clock edge ends the transfer. mem_sel returns to 1, the partial byte is never loaded, and a read strobe is needed before a new unlock. If bit 36 is 1, rst_pin_n is ignored.
- R10: dq0_oe is 0 in every cycle outside the transfer phase, including read strobes while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-clock read cycle strobe |
| wr_stb | input | 1 | One-clock write cycle strobe |
| dq0_in | input | 1 | Data bit 0 from the bus |
| rst_pin_n | input | 1 | Active-low transfer abort pin |
| clk_regs | input | 64 | Current clock register contents, register r in bits 8r+7:8r |
| mem_sel | output | 1 | SRAM select, 0 during the transfer phase |
| dq0_out | output | 1 | Data bit 0 returned on transfer reads |
| dq0_oe | output | 1 | Drive enable for dq0_out |
| load_vld | output | 1 | One-clock pulse committing a written byte |
| load_idx | output | 3 | Register index of the committed byte |
| load_byte | output | 8 | Committed byte value |

## Verification
The bench targets the points at which recognition can go wrong. It sends a key with one flipped bit followed by correct bits, and a design whose pointer skipped instead of freezing would unlock. It sends a key prefix, then a read, then only the remainder, and a design that kept its pointer across reads would unlock. It also sends a full key straight after a transfer with no read in between, which must not unlock. On the transfer side, the bench changes clk_regs after unlock, so a design reading live data returns the wrong bits. It mixes reads into byte groups, where a design that commits partial groups would pulse load_vld. It pulses rst_pin_n under both settings of the reset-enable bit, which shows a design that ignores the bit or aborts too eagerly.

// File: rtl/skgate_pkg.sv
package skgate_pkg;

  localparam int unsigned KEY_BITS = 64;

  // bytes C5,3A,A3,5C twice, first byte in the low bits, consumed LSB first
  localparam logic [KEY_BITS-1:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

  typedef enum logic {
    PH_LOCKED = 1'b0,
    PH_XFER   = 1'b1
  } phase_e;

endpackage

// File: rtl/skgate_rst_sync.sv
module skgate_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/skgate_matcher.sv
module skgate_matcher #(
  parameter int unsigned        KEY_W = 64,
  parameter logic [KEY_W-1:0]   KEY   = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rd,
  input  logic wr,
  input  logic din,
  output logic hit
);

  localparam int unsigned PW = $clog2(KEY_W);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          fail_q, fail_d;
  logic          bit_ok, at_last, upd;

  always_comb begin
    bit_ok  = (din == KEY[ptr_q]);
    at_last = (ptr_q == PW'(KEY_W - 1));
    hit     = en && wr && !rd && !fail_q && bit_ok && at_last;
    ptr_d   = ptr_q;
    fail_d  = fail_q;
    upd     = 1'b0;
    if (en && rd) begin
      ptr_d  = '0;
      fail_d = 1'b0;
      upd    = 1'b1;
    end else if (en && wr && !fail_q) begin
      upd = 1'b1;
      if (!bit_ok) begin
        fail_d = 1'b1;
      end else if (at_last) begin
        ptr_d  = '0;
        fail_d = 1'b1;   // a read is needed before the next attempt
      end else begin
        ptr_d = ptr_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fail_q <= 1'b0;
    end else if (upd) begin
      ptr_q  <= ptr_d;
      fail_q <= fail_d;
    end
  end

endmodule

// File: rtl/skgate_xfer.sv
module skgate_xfer
  import skgate_pkg::*;
#(
  parameter int unsigned XFER_W    = 64,
  parameter int unsigned GRP_W     = 8,
  parameter int unsigned RSTEN_BIT = 36
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start,
  input  logic [XFER_W-1:0]                       snap_in,
  input  logic                                    rd,
  input  logic                                    wr,
  input  logic                                    din,
  input  logic                                    pin_n,
  output logic                                    active,
  output logic                                    dq_out,
  output logic                                    dq_oe,
  output logic                                    load_vld,
  output logic [$clog2(XFER_W)-$clog2(GRP_W)-1:0] load_idx,
  output logic [GRP_W-1:0]                        load_byte
);

  localparam int unsigned CW = $clog2(XFER_W);
  localparam int unsigned GW = $clog2(GRP_W);
  localparam int unsigned IW = CW - GW;

  phase_e            phase_q, phase_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [XFER_W-1:0] snap_q, snap_d;
  logic [GRP_W-2:0]  shad_q, shad_d;
  logic              gok_q, gok_d;
  logic              lv_q, lv_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [GRP_W-1:0]  byte_q, byte_d;

  logic in_x, abort, step, grp_all, grp_last, commit, ctl_en;

  always_comb begin
    in_x     = (phase_q == PH_XFER);
    abort    = in_x && !snap_q[RSTEN_BIT] && !pin_n;
    step     = in_x && !abort && (rd || wr);
    grp_all  = (cnt_q[GW-1:0] == '0) || gok_q;
    grp_last = (cnt_q[GW-1:0] == GW'(GRP_W - 1));
    commit   = step && wr && grp_last && grp_all;
    dq_out   = snap_q[cnt_q];
    dq_oe    = in_x && !abort && rd && !wr;

    phase_d = phase_q;
    cnt_d   = cnt_q;
    snap_d  = snap_q;
    shad_d  = shad_q;
    gok_d   = gok_q;
    lv_d    = commit;
    idx_d   = idx_q;
    byte_d  = byte_q;
    ctl_en  = 1'b0;

    if (start && !in_x) begin
      ctl_en  = 1'b1;
      phase_d = PH_XFER;
      cnt_d   = '0;
      snap_d  = snap_in;
    end else if (abort) begin
      ctl_en  = 1'b1;
      phase_d = PH_LOCKED;
      cnt_d   = '0;
    end else if (step) begin
      ctl_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
      gok_d  = grp_all && wr;
      if (wr) shad_d = {din, shad_q[GRP_W-2:1]};
      if (commit) begin
        idx_d  = cnt_q[CW-1:GW];
        byte_d = {din, shad_q};
      end
      if (cnt_q == CW'(XFER_W - 1)) phase_d = PH_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOCKED;
      cnt_q   <= '0;
      snap_q  <= '0;
      shad_q  <= '0;
      gok_q   <= 1'b0;
    end else if (ctl_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      snap_q  <= snap_d;
      shad_q  <= shad_d;
      gok_q   <= gok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q   <= 1'b0;
      idx_q  <= '0;
      byte_q <= '0;
    end else begin
      lv_q <= lv_d;
      if (commit) begin
        idx_q  <= idx_d;
        byte_q <= byte_d;
      end
    end
  end

  assign active    = in_x;
  assign load_vld  = lv_q;
  assign load_idx  = idx_q;
  assign load_byte = byte_q;

endmodule

// File: rtl/serial_key_gate.sv
module serial_key_gate #(
  parameter int unsigned      KEY_W     = skgate_pkg::KEY_BITS,
  parameter logic [KEY_W-1:0] KEY       = skgate_pkg::UNLOCK_KEY,
  parameter int unsigned      XFER_W    = 64,
  parameter int unsigned      GRP_W     = 8,
  parameter int unsigned      RSTEN_BIT = 36
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    rd_stb,
  input  logic                                    wr_stb,
  input  logic                                    dq0_in,
  input  logic                                    rst_pin_n,
  input  logic [XFER_W-1:0]                       clk_regs,
  output logic                                    mem_sel,
  output logic                                    dq0_out,
  output logic                                    dq0_oe,
  output logic                                    load_vld,
  output logic [$clog2(XFER_W)-$clog2(GRP_W)-1:0] load_idx,
  output logic [GRP_W-1:0]                        load_byte
);

  logic rst_n_s;
  logic key_hit;
  logic xfer_on;

  skgate_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  skgate_matcher #(
    .KEY_W (KEY_W),
    .KEY   (KEY)
  ) u_match (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (!xfer_on),
    .rd    (rd_stb),
    .wr    (wr_stb),
    .din   (dq0_in),
    .hit   (key_hit)
  );

  skgate_xfer #(
    .XFER_W    (XFER_W),
    .GRP_W     (GRP_W),
    .RSTEN_BIT (RSTEN_BIT)
  ) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (key_hit),
    .snap_in   (clk_regs),
    .rd        (rd_stb),
    .wr        (wr_stb),
    .din       (dq0_in),
    .pin_n     (rst_pin_n),
    .active    (xfer_on),
    .dq_out    (dq0_out),
    .dq_oe     (dq0_oe),
    .load_vld  (load_vld),
    .load_idx  (load_idx),
    .load_byte (load_byte)
  );

  assign mem_sel = !xfer_on;

endmodule

// File: rtl/skgate_chk.sv
module skgate_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_stb,
  input logic wr_stb,
  input logic rst_pin_n,
  input logic mem_sel,
  input logic dq0_oe,
  input logic load_vld
);

  a_r10_oe_only_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    dq0_oe |-> !mem_sel);

  a_r5_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    dq0_oe |-> rd_stb);

  a_r6_load_after_xfer_write: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld |-> $past(wr_stb && !mem_sel));

  a_r6_load_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld |=> !load_vld);

  a_r2_unlock_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_sel) |-> $past(wr_stb && !rd_stb));

  a_r8_idle_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb && rst_pin_n) |=> $stable(mem_sel));

endmodule

bind serial_key_gate skgate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .rst_pin_n (rst_pin_n),
  .mem_sel   (mem_sel),
  .dq0_oe    (dq0_oe),
  .load_vld  (load_vld)
);

// File: tb/serial_key_gate_bench.sv
module serial_key_gate_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, rd_stb, wr_stb, dq0_in, rst_pin_n;
  logic [63:0] clk_regs;
  logic        mem_sel, dq0_out, dq0_oe, load_vld;
  logic [2:0]  load_idx;
  logic [7:0]  load_byte;

  int checks = 0;
  int errors = 0;

  logic s_mem, s_oe, s_out, s_lv;
  logic [2:0] s_li;
  logic [7:0] s_lb;
  logic [63:0] snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_key_gate u_serial_key_gate (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .dq0_in(dq0_in), .rst_pin_n(rst_pin_n), .clk_regs(clk_regs),
    .mem_sel(mem_sel), .dq0_out(dq0_out), .dq0_oe(dq0_oe),
    .load_vld(load_vld), .load_idx(load_idx), .load_byte(load_byte)
  );

  function automatic logic key_bit(input int i);
    logic [7:0] b;
    case ((i / 8) % 4)
      0: b = 8'hC5;
      1: b = 8'h3A;
      2: b = 8'hA3;
      default: b = 8'h5C;
    endcase
    return b[i % 8];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic d);
    @(negedge clk);
    rd_stb = r; wr_stb = w; dq0_in = d;
    #1;
    s_mem = mem_sel; s_oe = dq0_oe; s_out = dq0_out;
    @(posedge clk);
    #1;
    s_lv = load_vld; s_li = load_idx; s_lb = load_byte;
    rd_stb = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic send_key(input int from, input int upto, input int flip);
    for (int i = from; i <= upto; i++) cyc(1'b0, 1'b1, key_bit(i) ^ (i == flip));
  endtask

  task automatic unlock();
    snap = clk_regs;
    cyc(1'b1, 1'b0, 1'b0);
    send_key(0, 63, -1);
  endtask

  // mode per group: 0 all writes, 1 all reads, 2 mixed
  task automatic xfer_run(input int start_bit);
    logic [7:0] gb;
    logic gok, isw, d;
    int mode;
    mode = 0;
    gok = 1'b1;
    gb = '0;
    for (int i = start_bit; i < 64; i++) begin
      if (i % 8 == 0 || i == start_bit) begin
        mode = int'($urandom_range(0, 2));
        gok = 1'b1;
      end
      isw = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : logic'($urandom_range(0, 1));
      d = logic'($urandom_range(0, 1));
      cyc(!isw, isw, d);
      if (!isw) begin
        chk("R5", "read bit", {63'd0, s_out}, {63'd0, snap[i]});
        chk("R5", "oe on read", {63'd0, s_oe}, 64'd1);
      end
      gok = gok && isw;
      gb[i % 8] = d;
      if (i % 8 == 7) begin
        chk(gok ? "R6" : "R7", "load pulse", {63'd0, s_lv}, {63'd0, gok});
        if (gok) begin
          chk("R6", "load index", {61'd0, s_li}, i / 8);
          chk("R6", "load byte", {56'd0, s_lb}, {56'd0, gb});
        end
      end
    end
    cyc(1'b0, 1'b0, 1'b0);
    chk("R8", "relocked after 64", {63'd0, s_mem}, 64'd1);
  endtask

  function automatic logic [63:0] rnd64(input logic rsten);
    logic [63:0] v;
    v = {$urandom(), $urandom()};
    v[36] = rsten;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] gb;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; dq0_in = 1'b0;
    rst_pin_n = 1'b1; clk_regs = '0;
    repeat (3) @(negedge clk);
    chk("R1", "mem_sel", {63'd0, mem_sel}, 64'd1);
    chk("R1", "dq0_oe", {63'd0, dq0_oe}, 64'd0);
    chk("R1", "load_vld", {63'd0, load_vld}, 64'd0);
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, 1'b0, 1'b0);

    // R10 and R2: locked read, then full key
    clk_regs = rnd64(1'b1);
    snap = clk_regs;
    cyc(1'b1, 1'b0, 1'b0);
    chk("R10", "oe on locked read", {63'd0, s_oe}, 64'd0);
    send_key(0, 62, -1);
    chk("R2", "mem_sel during key", {63'd0, s_mem}, 64'd1);
    send_key(63, 63, -1);
    chk("R2", "mem_sel on last key write", {63'd0, s_mem}, 64'd1);
    clk_regs = ~clk_regs;
    cyc(1'b0, 1'b0, 1'b0);
    chk("R2", "unlocked", {63'd0, s_mem}, 64'd0);
    chk("R10", "oe idle in xfer", {63'd0, s_oe}, 64'd0);

    // R5: read all 64 bits of the snapshot while clk_regs differs
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      chk("R5", "snapshot bit", {63'd0, s_out}, {63'd0, snap[i]});
      chk("R5", "oe", {63'd0, s_oe}, 64'd1);
    end
    cyc(1'b0, 1'b0, 1'b0);
    chk("R8", "relocked", {63'd0, s_mem}, 64'd1);

    // R8: key without read after transfer
    send_key(0, 63, -1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R8", "no unlock without read", {63'd0, s_mem}, 64'd1);

    // R4: prefix, read, full key unlocks
    cyc(1'b1, 1'b0, 1'b0);
    send_key(0, 29, -1);
    unlock();
    cyc(1'b0, 1'b0, 1'b0);
    chk("R4", "restart after read", {63'd0, s_mem}, 64'd0);
    gb = '0;
    for (int i = 0; i < 64; i++) begin
      gb[i % 8] = logic'($urandom_range(0, 1));
      cyc(1'b0, 1'b1, gb[i % 8]);
      if (i % 8 == 7) begin
        chk("R6", "load pulse", {63'd0, s_lv}, 64'd1);
        chk("R6", "load index", {61'd0, s_li}, i / 8);
        chk("R6", "load byte", {56'd0, s_lb}, {56'd0, gb});
      end else begin
        chk("R6", "no early load", {63'd0, s_lv}, 64'd0);
      end
    end
    cyc(1'b0, 1'b0, 1'b0);
    chk("R8", "relocked after writes", {63'd0, s_mem}, 64'd1);

    // R4: prefix, read, remainder only stays locked
    cyc(1'b1, 1'b0, 1'b0);
    send_key(0, 29, -1);
    cyc(1'b1, 1'b0, 1'b0);
    send_key(30, 63, -1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R4", "remainder alone", {63'd0, s_mem}, 64'd1);

    // R3: mismatch freezes
    cyc(1'b1, 1'b0, 1'b0);
    send_key(0, 63, 20);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R3", "flipped bit", {63'd0, s_mem}, 64'd1);
    send_key(0, 63, -1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R3", "full key after mismatch", {63'd0, s_mem}, 64'd1);
    clk_regs = rnd64(1'b1);
    unlock();
    cyc(1'b0, 1'b0, 1'b0);
    chk("R3", "read clears freeze", {63'd0, s_mem}, 64'd0);
    xfer_run(0);

    // R7: group with one read inside
    clk_regs = rnd64(1'b1);
    unlock();
    for (int i = 0; i < 8; i++) begin
      cyc(i == 4, i != 4, 1'b1);
      if (i == 7) chk("R7", "mixed group", {63'd0, s_lv}, 64'd0);
    end
    gb = 8'h00;
    for (int i = 0; i < 8; i++) begin
      gb[i] = logic'($urandom_range(0, 1));
      cyc(1'b0, 1'b1, gb[i]);
    end
    chk("R6", "group 1 load", {63'd0, s_lv}, 64'd1);
    chk("R6", "group 1 index", {61'd0, s_li}, 64'd1);
    chk("R6", "group 1 byte", {56'd0, s_lb}, {56'd0, gb});
    xfer_run(16);

    // random transfer rounds
    for (int k = 0; k < 6; k++) begin
      clk_regs = rnd64(1'b1);
      unlock();
      clk_regs = rnd64(1'b0);
      xfer_run(0);
    end

    // R9: abort with reset-enable 0
    clk_regs = rnd64(1'b0);
    unlock();
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1);
    rst_pin_n = 1'b0;
    cyc(1'b0, 1'b1, 1'b1);
    rst_pin_n = 1'b1;
    chk("R9", "no load on abort", {63'd0, s_lv}, 64'd0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R9", "aborted to locked", {63'd0, s_mem}, 64'd1);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b1, 1'b1);
      if (i == 1) chk("R9", "partial byte dropped", {63'd0, s_lv}, 64'd0);
    end
    chk("R9", "writes after abort no load", {63'd0, s_lv}, 64'd0);
    chk("R9", "still locked", {63'd0, s_mem}, 64'd1);
    send_key(0, 63, -1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R9", "read needed after abort", {63'd0, s_mem}, 64'd1);

    // R9: pin ignored with reset-enable 1
    clk_regs = rnd64(1'b1);
    unlock();
    rst_pin_n = 1'b0;
    gb = '0;
    for (int i = 0; i < 8; i++) begin
      gb[i] = logic'($urandom_range(0, 1));
      cyc(1'b0, 1'b1, gb[i]);
    end
    chk("R9", "load with pin ignored", {63'd0, s_lv}, 64'd1);
    chk("R9", "byte with pin ignored", {56'd0, s_lb}, {56'd0, gb});
    cyc(1'b0, 1'b0, 1'b0);
    chk("R9", "transfer continues", {63'd0, s_mem}, 64'd0);
    rst_pin_n = 1'b1;
    xfer_run(8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule